// File: doc/BRIEF.md
# USB Host Command and Status Register Slice

This block holds the part of a USB 2.0 host controller's command and status registers that the schedule engine reads. Software reaches it through a small word-wide read/write port. The engine receives four values from it: the two schedule enables, the asynchronous park count, and a mask that picks the current-index bits out of the frame index. The engine also receives a doorbell request. The engine answers that request with a pulse once it has dropped its cached copy of the asynchronous schedule. The block then records a status bit and retires the doorbell. It raises its interrupt only at an interrupt-threshold tick, and only when that status bit and its enable are both set.

The park count depends on the controller mode, which arrives on a 2-bit input where code 11b means host. In device mode the count reads 0. On entry to host mode it starts at 3, and after that software may load any nonzero value.

Top module: `uhc_cmd_regs`

## Requirements
- R1: After a synchronous reset, all of the following hold: both schedule enables are 0, the frame-list code is 000b, the index mask is 1023, the park count is 0, the doorbell is 0, the status bit is 0, the interrupt enable is 0, the interrupt output is 0 and the read data is 0.
- R2: A write to address 0 loads three fields from the same word: the asynchronous enable from bit 5, the periodic enable from bit 4, and the 3-bit frame-list code from bits {15,3,2} (bit 15 is the most significant). The enable outputs show the new values one cycle after the write.
- R3: The index mask equals (1024 >> code) - 1. Code 000b therefore gives 1023 and code 111b gives 7. The mask is registered from the stored code, so it follows a code change one cycle later than the code itself.
- R4: While the mode input is not 11b, the park count is 0. On the first clock edge at which the mode is 11b after a non-host state, the park count becomes 3.
- R5: In host mode, a command write whose bits [9:8] are nonzero loads those bits into the park count. A value of 0 in those bits is ignored, and the previous count is kept.
- R6: A command write with bit 6 set raises the doorbell only if two conditions hold before the write: the stored mode is host and the stored asynchronous enable is 1. Any other doorbell write is dropped. Writing 0 to bit 6 never clears a raised doorbell.
- R7: An eviction pulse while the doorbell is raised sets the status bit (address 1, bit 5) at that edge. The doorbell clears at the following edge. An eviction pulse while the doorbell is low has no effect.
- R8: The interrupt output rises only at an edge where the threshold tick is 1, the status bit is set and the interrupt enable (address 2, bit 5) is 1. Between ticks it holds its value.
- R9: Writing 1 to bit 5 at address 1 clears the status bit. If a status set and a clear fall on the same edge, the set wins. The interrupt output falls one edge after the status bit or the enable becomes 0.
- R10: A read strobe returns the addressed register one cycle later and the data then holds. Address 0 returns the command fields at the bit positions of R2, with the doorbell at bit 6 and the park count at bits [9:8]. Address 1 returns the status bit and address 2 returns the enable, both at bit 5. Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode | input | 2 | Controller mode; 11b selects host |
| sw_we | input | 1 | Software write strobe |
| sw_re | input | 1 | Software read strobe |
| sw_addr | input | 2 | Register address |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Registered read data |
| evict_done | input | 1 | Engine pulse: cached asynchronous state evicted |
| thr_tick | input | 1 | Interrupt-threshold point |
| async_en | output | 1 | Process the asynchronous schedule |
| periodic_en | output | 1 | Process the periodic schedule |
| park_cnt | output | 2 | Back-to-back transactions allowed per high-speed queue head |
| fidx_mask | output | 10 | Frame-index bits that form the list index |
| db_req | output | 1 | Async-advance doorbell pending |
| irq | output | 1 | Async-advance interrupt |

## Verification
Most results appear one edge after the stimulus that causes them: the enables, the park count, the doorbell set, the status set or clear, and the read data. Three results take longer. The mask arrives two edges after a code write. The doorbell clears one edge after the status bit is set. The interrupt moves one edge after the threshold tick, or one edge after the status bit or the enable drops. The bench keeps a cycle-level reference state that it advances from the same inputs the design sees, at each rising edge. It compares every output 1 ns after each edge, so each delayed result is checked in exactly the cycle it falls due. Directed sequences cover all eight frame-list codes, a zero park write, dropped doorbells, and the full eviction and interrupt handshake. Seeded random traffic with mode changes follows.

// File: rtl/uhc_cmd_pkg.sv
package uhc_cmd_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  // Register addresses
  localparam logic [ADDR_W-1:0] A_CMD = 2'd0;
  localparam logic [ADDR_W-1:0] A_STS = 2'd1;
  localparam logic [ADDR_W-1:0] A_IEN = 2'd2;

  // Command word bit positions
  localparam int B_FLS0 = 2;
  localparam int B_FLS1 = 3;
  localparam int B_PEN  = 4;
  localparam int B_AEN  = 5;
  localparam int B_DB   = 6;
  localparam int B_PARK = 8;
  localparam int B_FLS2 = 15;

  // Status and interrupt-enable bit
  localparam int B_AADV = 5;

  localparam logic [1:0] MODE_HOST = 2'b11;

  typedef struct packed {
    logic       aen;
    logic       pen;
    logic [2:0] fls;
  } cmd_fields_t;
endpackage

// File: rtl/uhc_park_ctrl.sv
module uhc_park_ctrl #(
  parameter int PARK_W     = 2,
  parameter int PARK_ENTRY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_now,
  input  logic              wr_en,
  input  logic [PARK_W-1:0] wr_val,
  output logic              host_q,
  output logic [PARK_W-1:0] park_q
);
  localparam logic [PARK_W-1:0] ENTRY_VAL = PARK_W'(PARK_ENTRY);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q <= 1'b0;
      park_q <= '0;
    end else begin
      host_q <= host_now;
      if (!host_now)
        park_q <= '0;
      else if (!host_q)
        park_q <= ENTRY_VAL;
      else if (wr_en && (wr_val != '0))
        park_q <= wr_val;
    end
  end

  // R4
  park_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (park_q != '0) == host_q);

  // R5
  park_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(host_q) && host_q && !$past(wr_en)) |-> $stable(park_q));
endmodule

// File: rtl/uhc_doorbell.sv
module uhc_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic host,
  input  logic aen,
  input  logic ring_wr,
  input  logic ack_wr,
  input  logic ien,
  input  logic evict_done,
  input  logic thr_tick,
  output logic db_q,
  output logic sts_q,
  output logic irq_q
);
  logic clr_pend;
  logic hit;

  assign hit = evict_done && db_q && !clr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      db_q     <= 1'b0;
      clr_pend <= 1'b0;
      sts_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      clr_pend <= hit;
      if (clr_pend)
        db_q <= 1'b0;
      else if (ring_wr && host && aen)
        db_q <= 1'b1;

      if (hit)
        sts_q <= 1'b1;
      else if (ack_wr)
        sts_q <= 1'b0;

      if (!(sts_q && ien))
        irq_q <= 1'b0;
      else if (thr_tick)
        irq_q <= 1'b1;
    end
  end

  // R6
  db_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(db_q) |-> $past(host && aen && ring_wr));

  // R7
  db_retire_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(db_q) |-> $past(sts_q));

  // R8
  irq_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(thr_tick && sts_q && ien));

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_q) && !$past(sts_q)) |-> !irq_q);
endmodule

// File: rtl/uhc_flsize_mask.sv
module uhc_flsize_mask #(
  parameter int FIDX_W = 10,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [FIDX_W-1:0] mask_q
);
  localparam logic [FIDX_W-1:0] FULL = '1;

  logic [FIDX_W:0] mask_p1;
  assign mask_p1 = {1'b0, mask_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= FULL;
    else     mask_q <= FULL >> code;
  end

  // R3
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_p1) == 1);
endmodule

// File: rtl/uhc_cmd_regs.sv
module uhc_cmd_regs
  import uhc_cmd_pkg::*;
#(
  parameter int FIDX_W     = 10,
  parameter int PARK_W     = 2,
  parameter int PARK_ENTRY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ctrl_mode,
  input  logic              sw_we,
  input  logic              sw_re,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              evict_done,
  input  logic              thr_tick,
  output logic              async_en,
  output logic              periodic_en,
  output logic [PARK_W-1:0] park_cnt,
  output logic [FIDX_W-1:0] fidx_mask,
  output logic              db_req,
  output logic              irq
);
  cmd_fields_t cmd_q;
  logic        ien_q;
  logic        host_q;
  logic        sts_q;
  logic        wr_cmd, wr_sts, wr_ien;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cmd = sw_we && (sw_addr == A_CMD);
  assign wr_sts = sw_we && (sw_addr == A_STS);
  assign wr_ien = sw_we && (sw_addr == A_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        cmd_q.aen <= sw_wdata[B_AEN];
        cmd_q.pen <= sw_wdata[B_PEN];
        cmd_q.fls <= {sw_wdata[B_FLS2], sw_wdata[B_FLS1], sw_wdata[B_FLS0]};
      end
      if (wr_ien) ien_q <= sw_wdata[B_AADV];
    end
  end

  uhc_park_ctrl #(.PARK_W(PARK_W), .PARK_ENTRY(PARK_ENTRY)) u_park (
    .clk(clk), .rst(rst),
    .host_now(ctrl_mode == MODE_HOST),
    .wr_en(wr_cmd),
    .wr_val(sw_wdata[B_PARK +: PARK_W]),
    .host_q(host_q),
    .park_q(park_cnt)
  );

  uhc_doorbell u_db (
    .clk(clk), .rst(rst),
    .host(host_q), .aen(cmd_q.aen),
    .ring_wr(wr_cmd && sw_wdata[B_DB]),
    .ack_wr(wr_sts && sw_wdata[B_AADV]),
    .ien(ien_q),
    .evict_done(evict_done), .thr_tick(thr_tick),
    .db_q(db_req), .sts_q(sts_q), .irq_q(irq)
  );

  uhc_flsize_mask #(.FIDX_W(FIDX_W), .CODE_W(3)) u_mask (
    .clk(clk), .rst(rst), .code(cmd_q.fls), .mask_q(fidx_mask)
  );

  always_comb begin
    rd_mux = '0;
    case (sw_addr)
      A_CMD: begin
        rd_mux[B_FLS0]            = cmd_q.fls[0];
        rd_mux[B_FLS1]            = cmd_q.fls[1];
        rd_mux[B_FLS2]            = cmd_q.fls[2];
        rd_mux[B_PEN]             = cmd_q.pen;
        rd_mux[B_AEN]             = cmd_q.aen;
        rd_mux[B_DB]              = db_req;
        rd_mux[B_PARK +: PARK_W]  = park_cnt;
      end
      A_STS:   rd_mux[B_AADV] = sts_q;
      A_IEN:   rd_mux[B_AADV] = ien_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        sw_rdata <= '0;
    else if (sw_re) sw_rdata <= rd_mux;
  end

  assign async_en    = cmd_q.aen;
  assign periodic_en = cmd_q.pen;

  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_cmd) |-> ($stable(async_en) && $stable(periodic_en)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_re) |-> $stable(sw_rdata));
endmodule

// File: tb/uhc_cmd_regs_bench.sv
module uhc_cmd_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ctrl_mode = 2'b00;
  logic        sw_we = 1'b0, sw_re = 1'b0;
  logic [1:0]  sw_addr = 2'd0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        evict_done = 1'b0, thr_tick = 1'b0;
  logic        async_en, periodic_en, db_req, irq;
  logic [1:0]  park_cnt;
  logic [9:0]  fidx_mask;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  uhc_cmd_regs u_uhc_cmd_regs (
    .clk(clk), .rst(rst), .ctrl_mode(ctrl_mode),
    .sw_we(sw_we), .sw_re(sw_re), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .evict_done(evict_done), .thr_tick(thr_tick),
    .async_en(async_en), .periodic_en(periodic_en),
    .park_cnt(park_cnt), .fidx_mask(fidx_mask),
    .db_req(db_req), .irq(irq)
  );

  // reference state
  logic m_host, m_db, m_clr, m_sts, m_ien, m_irq, m_aen, m_pen;
  logic [1:0]  m_park;
  logic [2:0]  m_fls;
  logic [9:0]  m_mask;
  logic [31:0] m_rd;

  task automatic model_reset();
    m_host = 0; m_db = 0; m_clr = 0; m_sts = 0; m_ien = 0; m_irq = 0;
    m_aen = 0; m_pen = 0; m_park = 0; m_fls = 0; m_mask = 10'h3FF; m_rd = 0;
  endtask

  function automatic logic [31:0] rd_word(input logic [1:0] a);
    logic [31:0] w = '0;
    case (a)
      2'd0: begin
        w[2] = m_fls[0]; w[3] = m_fls[1]; w[15] = m_fls[2];
        w[4] = m_pen; w[5] = m_aen; w[6] = m_db; w[9:8] = m_park;
      end
      2'd1: w[5] = m_sts;
      2'd2: w[5] = m_ien;
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 async_en", 32'(async_en), 32'(m_aen));
    chk("R2 periodic_en", 32'(periodic_en), 32'(m_pen));
    chk("R3 fidx_mask", 32'(fidx_mask), 32'(m_mask));
    chk("R4/R5 park_cnt", 32'(park_cnt), 32'(m_park));
    chk("R6/R7 db_req", 32'(db_req), 32'(m_db));
    chk("R8/R9 irq", 32'(irq), 32'(m_irq));
    chk("R10 sw_rdata", sw_rdata, m_rd);
  endtask

  task automatic step(input logic [1:0] mode, input logic we, input logic re,
                      input logic [1:0] a, input logic [31:0] wd,
                      input logic ev, input logic tk);
    logic hn, hit, ring;
    logic n_host, n_db, n_clr, n_sts, n_ien, n_irq, n_aen, n_pen;
    logic [1:0] n_park; logic [2:0] n_fls; logic [9:0] n_mask; logic [31:0] n_rd;
    ctrl_mode = mode; sw_we = we; sw_re = re; sw_addr = a; sw_wdata = wd;
    evict_done = ev; thr_tick = tk;
    hn = (mode == 2'b11);
    n_host = hn;
    if (!hn) n_park = 0;
    else if (!m_host) n_park = 2'd3;
    else if (we && a == 0 && wd[9:8] != 0) n_park = wd[9:8];
    else n_park = m_park;
    ring = we && a == 0 && wd[6] && m_host && m_aen;
    n_db = m_clr ? 1'b0 : (ring ? 1'b1 : m_db);
    hit = ev && m_db && !m_clr;
    n_clr = hit;
    n_sts = hit ? 1'b1 : ((we && a == 1 && wd[5]) ? 1'b0 : m_sts);
    n_ien = (we && a == 2) ? wd[5] : m_ien;
    n_irq = !(m_sts && m_ien) ? 1'b0 : (tk ? 1'b1 : m_irq);
    if (we && a == 0) begin
      n_aen = wd[5]; n_pen = wd[4]; n_fls = {wd[15], wd[3], wd[2]};
    end else begin
      n_aen = m_aen; n_pen = m_pen; n_fls = m_fls;
    end
    n_mask = 10'h3FF >> m_fls;
    n_rd = re ? rd_word(a) : m_rd;
    @(posedge clk); #1;
    m_host = n_host; m_park = n_park; m_db = n_db; m_clr = n_clr; m_sts = n_sts;
    m_ien = n_ien; m_irq = n_irq; m_aen = n_aen; m_pen = n_pen; m_fls = n_fls;
    m_mask = n_mask; m_rd = n_rd;
    check_all();
  endtask

  task automatic idle(input logic [1:0] mode, input int n);
    for (int i = 0; i < n; i++) step(mode, 0, 1, 2'd0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    model_reset();
    // R1: reset state
    check_all();
    chk("R1 status", rd_word(2'd1), 32'd0);

    // R4: enter host mode, park becomes 3
    step(2'b11, 0, 1, 2'd0, 0, 0, 0);
    // R5: zero park write ignored, asynchronous enable set
    step(2'b11, 1, 0, 2'd0, 32'h0000_0020, 0, 0);
    step(2'b11, 1, 1, 2'd0, 32'h0000_0220, 0, 0);
    // R8: enable interrupt
    step(2'b11, 1, 0, 2'd2, 32'h20, 0, 0);
    // R6: ring the doorbell
    step(2'b11, 1, 1, 2'd0, 32'h0000_0060, 0, 0);
    // R7: eviction sets status then retires doorbell
    step(2'b11, 0, 1, 2'd1, 0, 1, 0);
    idle(2'b11, 3);
    // R8: interrupt waits for the tick
    step(2'b11, 0, 0, 2'd0, 0, 0, 1);
    idle(2'b11, 2);
    // R9: W1C clears status, interrupt falls
    step(2'b11, 1, 1, 2'd1, 32'h20, 0, 0);
    idle(2'b11, 2);
    // R6: doorbell dropped with asynchronous schedule off, then in device mode
    step(2'b11, 1, 0, 2'd0, 32'h0000_0000, 0, 0);
    step(2'b11, 1, 1, 2'd0, 32'h0000_0040, 0, 0);
    step(2'b00, 1, 0, 2'd0, 32'h0000_0020, 0, 0);
    step(2'b00, 1, 1, 2'd0, 32'h0000_0360, 0, 0);
    idle(2'b00, 2);
    // R3: every frame-list code
    for (int c = 0; c < 8; c++) begin
      logic [31:0] w;
      w = '0; w[15] = c[2]; w[3] = c[1]; w[2] = c[0];
      step(2'b11, 1, 0, 2'd0, w, 0, 0);
      idle(2'b11, 2);
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      logic [31:0] wd;
      md = ($urandom % 20 == 0) ? 2'($urandom) : 2'b11;
      wd = $urandom;
      if ($urandom % 2 == 0) wd[5] = 1'b1;
      step(md, ($urandom % 3) == 0, $urandom % 2 == 0, 2'($urandom), wd,
           ($urandom % 6) == 0, ($urandom % 5) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule